// File: doc/BRIEF.md
# Programmable Three-Channel Color Matrix Converter

The block maps every incoming pixel, made of three components, onto a new triple. Each output component is a weighted sum of the three inputs plus a constant. The nine weights and three constants are 13-bit two's-complement numbers held in an internal coefficient bank. The bank loads each value in two halves through a narrow load port and comes out of reset with a colour-space preset. A 2-bit range code moves the binary point of every weight and constant, so the same 13 bits cover a gain span of 1, 2 or 4.

The datapath has three register stages:

- The first stage forms the nine products.
- The second stage sums each row with its scaled constant and a rounding term.
- The third stage shifts the sum down and saturates it to the component width.

With the enable low, each pixel is carried through unchanged and leaves after the same number of clocks. The enable, the range code and the coefficients are all taken with the pixel in the cycle that pixel is presented.

Top module: `color_matrix`

## Requirements
- R1: For output channel `ch` (0, 1, 2), with `w[ch][k]` the signed weight at bank index 4*ch+k (k = 0..2) and `c[ch]` the signed constant at bank index 4*ch+3, the output is `clamp((w0*in0 + w1*in1 + w2*in2 + c*4096 + 2^(s-1)) >>> s)`. Here `in0..in2` are the unsigned input components and `>>>` is a floor (arithmetic) shift.
- R2: The shift `s` follows `rng_i`: 00 gives 12, 01 gives 11, and 10 or 11 gives 10. A weight of 2048 is therefore unity in mode 01, and the constant is worth 1, 2 or 4 output steps per unit.
- R3: Rounding is half-up. An exact half step of the shifted result rounds toward plus infinity.
- R4: Results below 0 give 0, and results above 2^DW-1 give 2^DW-1.
- R5: `valid_o` equals `valid_i` delayed by exactly 3 clocks, for back-to-back pixels as well as isolated ones.
- R6: When `en_i` is 0 for a pixel, that pixel's components appear unchanged on `pix_o`, 3 clocks later.
- R7: After reset the bank holds 0x0C52, 0x0800, 0x0000, 0x19D7 at indices 0..3 and 0x1C54, 0x0800 at indices 4..5. Indices 6..11 hold zero.
- R8: A load with `ld_i`=1 updates bank entry `ld_sel_i`. With `ld_hi_i`=1, bits 12:8 take `ld_data_i[4:0]`; with `ld_hi_i`=0, bits 7:0 take `ld_data_i`. The new value applies from the next cycle's pixel, and selects 12..15 change nothing.
- R9: `en_i`, `rng_i` and the coefficients are sampled per pixel, so adjacent pixels may use different settings.
- R10: During and right after reset, `valid_o` is 0 and `pix_o` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Matrix enable for the current pixel, 0 = pass through |
| rng_i | input | 2 | Fixed-point range code |
| ld_i | input | 1 | Coefficient load strobe |
| ld_hi_i | input | 1 | 1 = load upper 5 bits, 0 = load lower 8 bits |
| ld_sel_i | input | 4 | Bank index, 4*channel + tap, tap 3 = constant |
| ld_data_i | input | 8 | Load data |
| valid_i | input | 1 | Input pixel valid |
| pix_i | input | 3*DW | Input components, element 0..2 |
| valid_o | output | 1 | Output pixel valid |
| pix_o | output | 3*DW | Output components, element 0..2 |

## Verification
The delay and bypass assertions assume that reset is held long enough for all pipeline registers to clear. They also assume the inputs hold stable values from one clock edge to the next. The bench drives every input on the falling edge and keeps `valid_i` low throughout reset.

The saturation assertions assume the second-stage sum never wraps. The accumulator is sized with headroom for the full signed weight and constant range, so every bench load value stays inside that guarantee, random ones included. Loads are issued only while `valid_i` is low, so a pixel never sees a half-written coefficient.

// File: rtl/color_matrix_pkg.sv
package color_matrix_pkg;
  localparam int unsigned NUM_CH   = 3;
  localparam int unsigned NUM_TAP  = 4;   // three weights + constant
  localparam int unsigned NUM_COEF = NUM_CH * NUM_TAP;
  localparam int unsigned LAT      = 3;
  localparam int unsigned LD_W     = 8;
  localparam int unsigned SEL_W    = 4;
endpackage

// File: rtl/cm_coef_bank.sv
module cm_coef_bank
  import color_matrix_pkg::*;
#(
  parameter int CW = 13
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           ld_i,
  input  logic                           ld_hi_i,
  input  logic [SEL_W-1:0]               ld_sel_i,
  input  logic [LD_W-1:0]                ld_data_i,
  output logic [NUM_COEF-1:0][CW-1:0]    coef_o
);
  localparam int HI_W = CW - LD_W;

  function automatic logic [12:0] rst_val(input int i);
    case (i)
      0:       return 13'h0C52;
      1:       return 13'h0800;
      3:       return 13'h19D7;
      4:       return 13'h1C54;
      5:       return 13'h0800;
      default: return 13'h0000;
    endcase
  endfunction

  logic [NUM_COEF-1:0][CW-1:0] coef_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_COEF; i++) coef_q[i] <= CW'(rst_val(i));
    end else if (ld_i) begin
      for (int i = 0; i < NUM_COEF; i++) begin
        if (ld_sel_i == SEL_W'(i)) begin
          if (ld_hi_i) coef_q[i][CW-1:LD_W] <= ld_data_i[HI_W-1:0];
          else         coef_q[i][LD_W-1:0]  <= ld_data_i;
        end
      end
    end
  end

  assign coef_o = coef_q;

  // R8: upper half lands in the selected entry
  p_load_upper_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && ld_hi_i && (ld_sel_i < SEL_W'(NUM_COEF))) |=>
      (coef_q[$past(ld_sel_i)][CW-1:LD_W] == $past(ld_data_i[HI_W-1:0])));
endmodule

// File: rtl/cm_dot3.sv
module cm_dot3
  import color_matrix_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 13
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_CH-1:0][DW-1:0]  pix_i,
  input  logic [NUM_TAP-1:0][CW-1:0] row_i,
  input  logic [1:0]                 rng_i,
  output logic [DW-1:0]              res_o
);
  localparam int PW   = CW + DW + 1;
  localparam int FB   = CW - 1;
  localparam int AW   = ((CW + DW + 4) > (CW + FB + 2)) ? (CW + DW + 4) : (CW + FB + 2);
  localparam int MAXV = (1 << DW) - 1;

  function automatic int frac_sh(input logic [1:0] r);
    case (r)
      2'b00:   return FB;
      2'b01:   return FB - 1;
      default: return FB - 2;
    endcase
  endfunction

  logic signed [PW-1:0] prod_d [NUM_CH];
  logic signed [PW-1:0] prod_q [NUM_CH];
  logic signed [CW-1:0] off_q;
  logic [1:0]           rng_q1, rng_q2;
  logic signed [AW-1:0] acc_d, acc_q;
  logic [DW-1:0]        res_d, res_q;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_mul
    always_comb begin
      logic signed [PW-1:0] a, b;
      a = PW'($signed(row_i[k]));
      b = PW'($signed({1'b0, pix_i[k]}));
      prod_d[k] = a * b;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NUM_CH; k++) prod_q[k] <= '0;
      off_q  <= '0;
      rng_q1 <= '0;
    end else begin
      for (int k = 0; k < NUM_CH; k++) prod_q[k] <= prod_d[k];
      off_q  <= $signed(row_i[NUM_TAP-1]);
      rng_q1 <= rng_i;
    end
  end

  // constant lives at 2^FB per unit in every mode; its weight follows the shift
  always_comb begin
    logic signed [AW-1:0] s, o, r;
    s = AW'(prod_q[0]) + AW'(prod_q[1]) + AW'(prod_q[2]);
    o = AW'(off_q);
    o = o <<< FB;
    r = AW'(1) <<< (frac_sh(rng_q1) - 1);
    acc_d = s + o + r;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      rng_q2 <= '0;
    end else begin
      acc_q  <= acc_d;
      rng_q2 <= rng_q1;
    end
  end

  always_comb begin
    logic signed [AW-1:0] t;
    t = acc_q >>> frac_sh(rng_q2);
    if (t < 0)                res_d = '0;
    else if (t > AW'(MAXV))   res_d = '1;
    else                      res_d = t[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_q <= '0;
    else         res_q <= res_d;
  end

  assign res_o = res_q;

  p_clamp_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q[AW-1] |=> (res_o == '0));

  p_clamp_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q >= ((AW'(MAXV) + AW'(1)) <<< frac_sh(rng_q2))) |=> (res_o == DW'(MAXV)));
endmodule

// File: rtl/color_matrix.sv
module color_matrix
  import color_matrix_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 13
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic [1:0]                rng_i,
  input  logic                      ld_i,
  input  logic                      ld_hi_i,
  input  logic [SEL_W-1:0]          ld_sel_i,
  input  logic [LD_W-1:0]           ld_data_i,
  input  logic                      valid_i,
  input  logic [NUM_CH-1:0][DW-1:0] pix_i,
  output logic                      valid_o,
  output logic [NUM_CH-1:0][DW-1:0] pix_o
);
  logic [NUM_COEF-1:0][CW-1:0]        coef;
  logic [NUM_CH-1:0][DW-1:0]          calc;
  logic [LAT-1:0]                     vld_q, en_q;
  logic [LAT-1:0][NUM_CH-1:0][DW-1:0] byp_q;
  logic [1:0]                         age_q;

  cm_coef_bank #(.CW(CW)) u_bank (
    .clk_i, .rst_ni, .ld_i, .ld_hi_i, .ld_sel_i, .ld_data_i,
    .coef_o (coef)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    cm_dot3 #(.DW(DW), .CW(CW)) u_dot (
      .clk_i, .rst_ni,
      .pix_i (pix_i),
      .row_i (coef[ch*NUM_TAP +: NUM_TAP]),
      .rng_i (rng_i),
      .res_o (calc[ch])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      en_q  <= '0;
      byp_q <= '0;
    end else begin
      vld_q <= {vld_q[LAT-2:0], valid_i};
      en_q  <= {en_q[LAT-2:0], en_i};
      byp_q <= {byp_q[LAT-2:0], pix_i};
    end
  end

  assign valid_o = vld_q[LAT-1];
  assign pix_o   = en_q[LAT-1] ? calc : byp_q[LAT-1];

  // cycles since reset, saturating, so 3-deep $past stays inside reset history
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  p_valid_delay_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3) |-> (valid_o == $past(valid_i, 3)));

  p_bypass_same_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((age_q == 2'd3) && valid_o && !$past(en_i, 3)) |-> (pix_o == $past(pix_i, 3)));
endmodule

// File: tb/color_matrix_test.sv
module color_matrix_test;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en, ld, ld_hi, valid;
  logic [1:0] rng;
  logic [3:0] ld_sel;
  logic [7:0] ld_data;
  logic [2:0][DW-1:0] pix;
  logic valid_out;
  logic [2:0][DW-1:0] pix_out;

  always #4 clk = ~clk;

  color_matrix #(.DW(DW), .CW(13)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .rng_i(rng),
    .ld_i(ld), .ld_hi_i(ld_hi), .ld_sel_i(ld_sel), .ld_data_i(ld_data),
    .valid_i(valid), .pix_i(pix), .valid_o(valid_out), .pix_o(pix_out)
  );

  typedef struct { bit v; int c[3]; string tag; } exp_t;
  exp_t q[$];
  int mc[12];
  int n_chk = 0, n_bad = 0;
  string cur_tag = "R1";

  function automatic int sv13(int raw);
    return (raw >= 4096) ? raw - 8192 : raw;
  endfunction

  task automatic check(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step();
    exp_t e, o;
    e.v = valid;
    e.tag = cur_tag;
    for (int ch = 0; ch < 3; ch++) begin
      if (!en) e.c[ch] = int'(pix[ch]);
      else begin
        int sh, acc;
        sh = (rng == 2'b00) ? 12 : (rng == 2'b01) ? 11 : 10;
        acc = sv13(mc[ch*4+3]) * 4096 + (1 << (sh - 1));
        for (int k = 0; k < 3; k++) acc += sv13(mc[ch*4+k]) * int'(pix[k]);
        acc = acc >>> sh;
        e.c[ch] = (acc < 0) ? 0 : (acc > 255) ? 255 : acc;
      end
    end
    q.push_back(e);
    if (ld && ld_sel < 12) begin
      if (ld_hi) mc[ld_sel] = (mc[ld_sel] & 255) | ((int'(ld_data) & 31) << 8);
      else       mc[ld_sel] = (mc[ld_sel] & 7936) | int'(ld_data);
    end
    @(posedge clk);
    @(negedge clk);
    o = q.pop_front();
    check({"R5 valid ", o.tag}, int'(valid_out), int'(o.v));
    if (o.v)
      for (int ch = 0; ch < 3; ch++) check(o.tag, int'(pix_out[ch]), o.c[ch]);
  endtask

  task automatic px(bit e, bit [1:0] r, int a, int b, int c, string tag);
    en = e; rng = r; valid = 1'b1; cur_tag = tag;
    pix[0] = 8'(a); pix[1] = 8'(b); pix[2] = 8'(c);
    step();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      valid = 1'b0;
      step();
    end
  endtask

  task automatic load(int sel, int val);
    valid = 1'b0; ld = 1'b1; ld_sel = 4'(sel);
    ld_hi = 1'b1; ld_data = 8'((val >> 8) & 31); step();
    ld_hi = 1'b0; ld_data = 8'(val & 255);        step();
    ld = 1'b0;
  endtask

  task automatic load_row(int ch, int w0, int w1, int w2, int off);
    load(ch*4, w0 & 8191); load(ch*4+1, w1 & 8191);
    load(ch*4+2, w2 & 8191); load(ch*4+3, off & 8191);
  endtask

  initial begin
    for (int i = 0; i < 12; i++) mc[i] = 0;
    mc[0] = 'h0C52; mc[1] = 'h0800; mc[3] = 'h19D7; mc[4] = 'h1C54; mc[5] = 'h0800;
    en = 0; rng = 0; ld = 0; ld_hi = 0; ld_sel = 0; ld_data = 0; valid = 0; pix = '0;
    q.push_back('{v: 0, c: '{0, 0, 0}, tag: "R10"});
    q.push_back('{v: 0, c: '{0, 0, 0}, tag: "R10"});
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 valid", int'(valid_out), 0);
    check("R10 pix", int'(pix_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after release", int'(pix_out), 0);

    // R7: reset preset observed through the outputs
    px(1, 2'b00, 255, 255, 255, "R7");
    px(1, 2'b00, 100, 50, 200, "R7");
    px(1, 2'b00, 0, 255, 0, "R7");
    idle(3);

    // R2: identity with unity 2048 in mode 01
    load_row(0, 2048, 0, 0, 0);
    load_row(1, 0, 2048, 0, 0);
    load_row(2, 0, 0, 2048, 0);
    px(1, 2'b01, 12, 34, 250, "R2");
    px(1, 2'b01, 0, 255, 128, "R2");
    // R9: settings change pixel to pixel
    px(1, 2'b00, 12, 34, 250, "R9");
    px(0, 2'b11, 7, 8, 9, "R9");
    px(1, 2'b10, 12, 34, 250, "R9");
    idle(3);

    // R3: half-step rounding, weight 0.5 in mode 01
    load_row(0, 1024, 0, 0, 0);
    load_row(1, -1024, 0, 0, 3);
    px(1, 2'b01, 5, 0, 0, "R3");
    px(1, 2'b01, 4, 0, 0, "R3");
    px(1, 2'b01, 1, 0, 0, "R3");
    idle(3);

    // R4: saturation both ends
    load_row(0, 4095, 0, 0, 200);
    load_row(1, 0, 4095, 0, -300);
    load_row(2, 0, 0, 4095, 0);
    px(1, 2'b00, 100, 250, 255, "R4");
    px(1, 2'b00, 255, 255, 0, "R4");
    idle(3);

    // R2: ranges 10/11 scale weights and constant
    load_row(0, 1024, 0, 0, 10);
    load_row(1, 0, -512, 0, 100);
    px(1, 2'b10, 40, 80, 1, "R2");
    px(1, 2'b11, 40, 80, 2, "R2");
    px(1, 2'b01, 40, 80, 3, "R2");
    idle(3);

    // R8: out-of-range select leaves bank unchanged
    load(13, 'h1FFF);
    load(15, 0);
    px(1, 2'b00, 40, 80, 200, "R8");
    idle(3);

    // R6: bypass back to back, and R5 continuous stream
    for (int i = 0; i < 8; i++)
      px(0, 2'(i), 31*i, 255 - 17*i, 5*i, "R6");
    idle(3);

    // R1: random matrices, constants and pixels
    for (int r = 0; r < 10; r++) begin
      for (int i = 0; i < 12; i++) load(i, int'($urandom_range(0, 8191)));
      for (int i = 0; i < 20; i++)
        px(($urandom_range(0, 7) != 0), 2'($urandom_range(0, 3)),
           int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
           int'($urandom_range(0, 255)), "R1");
      idle(3);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule